// File: doc/BRIEF.md
# Field Parity Detector with Alternating Parameter Bank Select

This block works out whether the current video field is odd or even when the only inputs are separate horizontal and vertical sync lines. It brings both syncs into the local clock domain and applies a selectable polarity to each. It then watches for a chosen transition of the vertical sync, rising or falling. At that transition it latches the level of horizontal sync, which the vertical edge lands on differently in odd and even fields. The latched level, optionally inverted, becomes the field flag.

The field flag drives two selections that downstream logic uses for the coming field. The first is the index of the active programming bank: bank A or bank B, both loaded ahead of time. The second is the video source select. Each selection can follow the field, so that it alternates from field to field, or it can be held at a fixed configured value. All three outputs change only at the reference edge, so a field is processed with one consistent setting from start to end. Configuration bits are static inputs that would come from a control register elsewhere on the chip.

Top module: `field_set_select`

## Requirements
- R1: While `rstN` is low, `fieldOut`, `setIdx` and `srcSel` are all 0.
- R2: A reference edge of vertical sync loads `fieldOut` with the synchronised horizontal sync level. A change on `vsyncIn` first sampled at clock edge j becomes visible on the outputs just after clock edge j+SYNC_STAGES.
- R3: `cfgEdgeFall`=0 selects the rising transition of the polarity-corrected vertical sync as the reference edge, and `cfgEdgeFall`=1 selects the falling transition. The other transition leaves all outputs unchanged.
- R4: `cfgVsInv`=1 inverts vertical sync before edge detection, so a raw low-going edge counts as rising.
- R5: `cfgHsInv`=1 inverts horizontal sync before it is captured.
- R6: `cfgFieldInv`=1 inverts the captured level before it is stored in `fieldOut`.
- R7: With `cfgSetAlt`=1, `setIdx` becomes `fieldOut` XOR `cfgSetSwap` at each reference edge. Index 0 means bank A and 1 means bank B.
- R8: With `cfgSetAlt`=0, `setIdx` takes `cfgSetFixed` at each reference edge, whatever the field.
- R9: With `cfgSrcAlt`=1, `srcSel` becomes `fieldOut` XOR `cfgSrcBase` at each reference edge. With `cfgSrcAlt`=0 it takes `cfgSrcBase`.
- R10: Between reference edges all three outputs hold their values, even if configuration inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hsyncIn | input | 1 | Raw horizontal sync |
| vsyncIn | input | 1 | Raw vertical sync |
| cfgHsInv | input | 1 | Invert horizontal sync polarity |
| cfgVsInv | input | 1 | Invert vertical sync polarity |
| cfgEdgeFall | input | 1 | Use the falling transition as the reference edge |
| cfgFieldInv | input | 1 | Invert the detected field flag |
| cfgSetAlt | input | 1 | Bank index follows the field |
| cfgSetSwap | input | 1 | Swap the bank assigned to each field |
| cfgSetFixed | input | 1 | Bank index used in static mode |
| cfgSrcAlt | input | 1 | Source select follows the field |
| cfgSrcBase | input | 1 | Static source, or phase of the alternation |
| fieldOut | output | 1 | Registered field flag |
| setIdx | output | 1 | Active bank index (0 = A, 1 = B) |
| srcSel | output | 1 | Video source select |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default 2. A latency that depends on the parameter, rather than on a fixed two flops, is therefore measured every cycle against a delay line in the model. The bench steps through all 512 configuration words. Each word is held for a span that is not a multiple of the sync periods, so every combination of polarity, edge, inversion and mapping is reached. Configuration changes often land in the middle of a field, which exercises the rule that outputs hold until the next reference edge.

// File: rtl/field_sel_pkg.sv
package field_sel_pkg;
  // Strobes passed from the sync/edge control to the output datapath
  typedef struct packed {
    logic refEdge;   // selected vertical sync transition seen this cycle
    logic hsLevel;   // polarity-corrected synchronised horizontal sync
  } fieldStrobe_t;
endpackage

// File: rtl/field_sync_ctrl.sv
module field_sync_ctrl
  import field_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hsyncIn,
  input  logic         vsyncIn,
  input  logic         cfgHsInv,
  input  logic         cfgVsInv,
  input  logic         cfgEdgeFall,
  output fieldStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] hsPipe;
  logic [LAST:0] vsPipe;
  logic          vsPrev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            hsPipe[0] <= 1'b0;
            vsPipe[0] <= 1'b0;
          end else begin
            hsPipe[0] <= hsyncIn;
            vsPipe[0] <= vsyncIn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            hsPipe[g] <= 1'b0;
            vsPipe[g] <= 1'b0;
          end else begin
            hsPipe[g] <= hsPipe[g-1];
            vsPipe[g] <= vsPipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vsPrev <= 1'b0;
    else       vsPrev <= vsPipe[LAST];
  end

  logic vsNow, vsOld, riseSeen, fallSeen;

  always_comb begin
    vsNow          = vsPipe[LAST] ^ cfgVsInv;
    vsOld          = vsPrev ^ cfgVsInv;
    riseSeen       = vsNow & ~vsOld;
    fallSeen       = ~vsNow & vsOld;
    strobe.refEdge = cfgEdgeFall ? fallSeen : riseSeen;
    strobe.hsLevel = hsPipe[LAST] ^ cfgHsInv;
  end
endmodule

// File: rtl/field_out_dp.sv
module field_out_dp
  import field_sel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  fieldStrobe_t strobe,
  input  logic         cfgFieldInv,
  input  logic         cfgSetAlt,
  input  logic         cfgSetSwap,
  input  logic         cfgSetFixed,
  input  logic         cfgSrcAlt,
  input  logic         cfgSrcBase,
  output logic         fieldOut,
  output logic         setIdx,
  output logic         srcSel
);
  logic fieldNext, setNext, srcNext;

  always_comb begin
    fieldNext = strobe.hsLevel ^ cfgFieldInv;
    setNext   = cfgSetAlt ? (fieldNext ^ cfgSetSwap) : cfgSetFixed;
    srcNext   = cfgSrcAlt ? (fieldNext ^ cfgSrcBase) : cfgSrcBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldOut <= 1'b0;
      setIdx   <= 1'b0;
      srcSel   <= 1'b0;
    end else if (strobe.refEdge) begin
      fieldOut <= fieldNext;
      setIdx   <= setNext;
      srcSel   <= srcNext;
    end
  end
endmodule

// File: rtl/field_set_select.sv
module field_set_select
  import field_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic hsyncIn,
  input  logic vsyncIn,
  input  logic cfgHsInv,
  input  logic cfgVsInv,
  input  logic cfgEdgeFall,
  input  logic cfgFieldInv,
  input  logic cfgSetAlt,
  input  logic cfgSetSwap,
  input  logic cfgSetFixed,
  input  logic cfgSrcAlt,
  input  logic cfgSrcBase,
  output logic fieldOut,
  output logic setIdx,
  output logic srcSel
);
  fieldStrobe_t strobe;

  field_sync_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .cfgHsInv(cfgHsInv), .cfgVsInv(cfgVsInv), .cfgEdgeFall(cfgEdgeFall),
    .strobe(strobe)
  );

  field_out_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgFieldInv(cfgFieldInv), .cfgSetAlt(cfgSetAlt), .cfgSetSwap(cfgSetSwap),
    .cfgSetFixed(cfgSetFixed), .cfgSrcAlt(cfgSrcAlt), .cfgSrcBase(cfgSrcBase),
    .fieldOut(fieldOut), .setIdx(setIdx), .srcSel(srcSel)
  );
endmodule

// File: rtl/field_set_select_chk.sv
module field_set_select_chk (
  input logic clk,
  input logic rstN,
  input logic refEdge,
  input logic hsLevel,
  input logic cfgFieldInv,
  input logic cfgSetAlt,
  input logic cfgSetSwap,
  input logic cfgSetFixed,
  input logic cfgSrcAlt,
  input logic cfgSrcBase,
  input logic fieldOut,
  input logic setIdx,
  input logic srcSel
);
  // R1: outputs cleared while reset is held
  always @(negedge clk)
    if (!rstN) p_reset_clear_r1: assert (!fieldOut && !setIdx && !srcSel);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !refEdge |=> ($stable(fieldOut) && $stable(setIdx) && $stable(srcSel)));

  p_field_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    refEdge |=> (fieldOut == ($past(hsLevel) ^ $past(cfgFieldInv))));

  p_alt_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refEdge && cfgSetAlt) |=> (setIdx == (fieldOut ^ $past(cfgSetSwap))));

  p_static_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (refEdge && !cfgSetAlt) |=> (setIdx == $past(cfgSetFixed)));

  p_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    refEdge |=> (srcSel == ($past(cfgSrcAlt) ? (fieldOut ^ $past(cfgSrcBase))
                                             : $past(cfgSrcBase))));
endmodule

bind field_set_select field_set_select_chk chk_i (
  .clk(clk), .rstN(rstN),
  .refEdge(strobe.refEdge), .hsLevel(strobe.hsLevel),
  .cfgFieldInv(cfgFieldInv), .cfgSetAlt(cfgSetAlt), .cfgSetSwap(cfgSetSwap),
  .cfgSetFixed(cfgSetFixed), .cfgSrcAlt(cfgSrcAlt), .cfgSrcBase(cfgSrcBase),
  .fieldOut(fieldOut), .setIdx(setIdx), .srcSel(srcSel)
);

// File: tb/field_set_select_tb_top.sv
`timescale 1ns/1ps
module field_set_select_tb_top;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hsyncIn = 1'b0, vsyncIn = 1'b0;
  logic cfgHsInv = 1'b0, cfgVsInv = 1'b0, cfgEdgeFall = 1'b0, cfgFieldInv = 1'b0;
  logic cfgSetAlt = 1'b0, cfgSetSwap = 1'b0, cfgSetFixed = 1'b0;
  logic cfgSrcAlt = 1'b0, cfgSrcBase = 1'b0;
  logic fieldOut, setIdx, srcSel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  field_set_select #(.SYNC_STAGES(N)) dut_i (
    .clk(clk), .rstN(rstN), .hsyncIn(hsyncIn), .vsyncIn(vsyncIn),
    .cfgHsInv(cfgHsInv), .cfgVsInv(cfgVsInv), .cfgEdgeFall(cfgEdgeFall),
    .cfgFieldInv(cfgFieldInv), .cfgSetAlt(cfgSetAlt), .cfgSetSwap(cfgSetSwap),
    .cfgSetFixed(cfgSetFixed), .cfgSrcAlt(cfgSrcAlt), .cfgSrcBase(cfgSrcBase),
    .fieldOut(fieldOut), .setIdx(setIdx), .srcSel(srcSel)
  );

  task automatic check(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural model state
  bit hq[$];
  bit vq[$];
  bit mField, mSet, mSrc;

  initial begin
    for (int i = 0; i <= N; i++) begin hq.push_back(1'b0); vq.push_back(1'b0); end
    mField = 0; mSet = 0; mSrc = 0;
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      hsyncIn = 1'b1; vsyncIn = 1'b1; cfgSetFixed = 1'b1; cfgSrcBase = 1'b1;
      check("R1", "fieldOut in reset", fieldOut, 1'b0);
      check("R1", "setIdx in reset", setIdx, 1'b0);
      check("R1", "srcSel in reset", srcSel, 1'b0);
    end
    hsyncIn = 1'b0; vsyncIn = 1'b0; cfgSetFixed = 1'b0; cfgSrcBase = 1'b0;
    rstN = 1'b1;
    for (int cyc = 0; cyc < 512 * 97; cyc++) begin
      @(negedge clk);
      begin
        // step model for the edge just taken (R2 latency: delay line of N)
        bit vNow, vOld, hLvl, isEdge, fNext;
        vNow = vq[N-1] ^ cfgVsInv;              // R4
        vOld = vq[N] ^ cfgVsInv;
        hLvl = hq[N-1] ^ cfgHsInv;              // R5
        isEdge = cfgEdgeFall ? (vOld && !vNow) : (!vOld && vNow);  // R3
        if (isEdge) begin
          fNext = hLvl ^ cfgFieldInv;           // R6
          mField = fNext;
          mSet = cfgSetAlt ? (fNext ^ cfgSetSwap) : cfgSetFixed;   // R7, R8
          mSrc = cfgSrcAlt ? (fNext ^ cfgSrcBase) : cfgSrcBase;    // R9
        end
        // otherwise model holds: R10
        hq.push_front(hsyncIn); void'(hq.pop_back());
        vq.push_front(vsyncIn); void'(vq.pop_back());
      end
      check("R2/R3/R4/R5/R6", "fieldOut", fieldOut, mField);
      check(cfgSetAlt ? "R7" : "R8", "setIdx", setIdx, mSet);
      check("R9/R10", "srcSel", srcSel, mSrc);
      // next stimulus
      hsyncIn = ((cyc / 5) % 2) == 1;
      vsyncIn = (cyc % 37) < 6;
      if (cyc % 97 == 50) begin
        int w;
        w = (cyc / 97) + 1;
        {cfgHsInv, cfgVsInv, cfgEdgeFall, cfgFieldInv, cfgSetAlt,
         cfgSetSwap, cfgSetFixed, cfgSrcAlt, cfgSrcBase} = 9'(w);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule